// File: doc/BRIEF.md
# Periodic Tick and Square-Wave Divider

This block counts pulses of a 32.768 kHz timebase, delivered as a one-cycle `tick` strobe in the system clock domain. From that single count it produces two outputs: a periodic event and a square wave. A 4-bit rate code picks one tap of the counter, and that tap sets both the event rate and the square-wave frequency. Changing the code therefore moves both outputs together. Each output still has its own enable.

Every periodic event sets a sticky flag. When the interrupt enable is set, the flag pulls an active-low, open-drain style request line low. Software clears the flag by reading the status register, which appears to this block as the `stat_rd` strobe. The periodic path has no link to any alarm logic.

Top module: `pint_sqw_div`

## Requirements
- R1: While `rst_n` is low and just after it is released, the divider count is zero, `pflag` is 0, `irqf` is 0, `irq_n` is 1 and `sqw_out` is 0.
- R2: For rate codes 3 to 15, a periodic event happens once every 2^(code-1) ticks. This spans 8192 Hz at code 3 down to 2 Hz at code 15. After reset, the first event falls on tick number 2^(code-1).
- R3: Code 1 gives an event every 128 ticks (256 Hz). Code 2 gives an event every 256 ticks (128 Hz).
- R4: Code 0 produces no periodic event and holds `sqw_out` at 0.
- R5: With `sqw_en` = 1 and a nonzero code, `sqw_out` has the same period as the event. It equals bit (p-1) of the tick count, where 2^p is the period. So it is low for the first half period after reset and falls in the same cycle that the event sets the flag.
- R6: With `sqw_en` = 0, `sqw_out` stays 0. Periodic events and `pflag` are unaffected.
- R7: An event sets `pflag` at the clock edge where it occurs. `pflag` then stays set whether or not `pie_en` is set.
- R8: `irqf` = `pflag` AND `pie_en`, and `irq_n` is its inverse. A change of `pie_en` shows on both outputs in the same cycle.
- R9: A `stat_rd` strobe with no coincident event clears `pflag` at that clock edge. `irq_n` is 1 from then on.
- R10: If a `stat_rd` strobe and an event fall on the same edge, `pflag` ends set, so the event is not lost.
- R11: A change of rate code takes effect at once on the running count. The divider does not restart.
- R12: The divider advances only on clock edges where `tick` is 1. Idle cycles change neither the count nor `pflag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| rate_sel | input | 4 | Rate code shared by the tick and the square wave |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic interrupt enable |
| stat_rd | input | 1 | Status-register read strobe; clears the flag |
| sqw_out | output | 1 | Square-wave output |
| pflag | output | 1 | Sticky periodic flag |
| irqf | output | 1 | Qualified interrupt-request flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `tick` is a single-cycle strobe and that `stat_rd` lasts exactly one cycle per read. They also assume that every input changes only away from the rising clock edge. The bench drives all inputs on the falling edge. It holds `tick` high for whole cycles, or pulses it for one cycle between idle cycles, and it never keeps `stat_rd` high for more than one cycle. With the strobe held high every cycle, each code can be swept in turn within a bounded run. The slowest code needs 2^14 cycles per period.

// File: rtl/pint_sqw_div.sv
module pint_sqw_div #(
  parameter int RATE_W = 4,
  parameter int DIV_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  input  logic              pie_en,
  input  logic              stat_rd,
  output logic              sqw_out,
  output logic              pflag,
  output logic              irqf,
  output logic              irq_n
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_q;
  logic [RATE_W-1:0] shamt;
  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] top_bit;
  logic active, evt;

  always_comb begin
    case (rate_sel)
      RATE_W'(0): shamt = '0;
      RATE_W'(1): shamt = RATE_W'(7);
      RATE_W'(2): shamt = RATE_W'(8);
      default:    shamt = rate_sel - RATE_W'(1);
    endcase
  end

  assign active  = (rate_sel != '0);
  assign mask    = (ONE << shamt) - ONE;
  assign top_bit = mask ^ (mask >> 1);
  assign evt     = tick && active && ((div_q & mask) == mask);

  assign sqw_out = sqw_en && active && |(div_q & top_bit);
  assign irqf    = pflag && pie_en;
  assign irq_n   = !irqf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      pflag <= 1'b0;
    end else begin
      if (tick) div_q <= div_q + ONE;
      if (evt) pflag <= 1'b1;
      else if (stat_rd) pflag <= 1'b0;
    end
  end

  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n) !sqw_en |-> !sqw_out); // R6
  AST_CODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |-> !sqw_out); // R4
  AST_CODE0_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0 && !pflag) |=> !pflag); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !pie_en |-> irq_n); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tick) |=> !pflag && irq_n); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stat_rd) |=> $stable(pflag) && $stable(div_q)); // R12
  AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pflag) |-> $past(tick)); // R7

endmodule

// File: tb/tb_pint_sqw_div.sv
module tb_pint_sqw_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic sqw_en = 1'b0, pie_en = 1'b0, stat_rd = 1'b0;
  logic sqw_out, pflag, irqf, irq_n;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pint_sqw_div dut (.clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel),
    .sqw_en(sqw_en), .pie_en(pie_en), .stat_rd(stat_rd), .sqw_out(sqw_out),
    .pflag(pflag), .irqf(irqf), .irq_n(irq_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int shift_of(input int c);
    if (c == 1) return 7;
    if (c == 2) return 8;
    return c - 1;
  endfunction

  task automatic do_reset(input int code);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; stat_rd = 1'b0; rate_sel = 4'(code);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    sqw_en = 1'b1; pie_en = 1'b1;
    do_reset(3);
    check(pflag == 0 && irq_n == 1 && irqf == 0 && sqw_out == 0, "R1 reset",
          {pflag, irqf, irq_n, sqw_out}, 4'b0010);

    // R2/R3/R5/R9 sweep over every nonzero code
    for (int c = 1; c < 16; c++) begin
      int s, p, bad_sq, bad_fl, bad_irq;
      s = shift_of(c); p = 1 << s;
      bad_sq = 0; bad_fl = 0; bad_irq = 0;
      sqw_en = 1'b1; pie_en = 1'b1;
      do_reset(c);
      tick = 1'b1;
      for (int n = 1; n <= 2 * p; n++) begin
        bit ef, es;
        step();
        stat_rd = 1'b0;
        ef = (n == p) || (n == 2 * p);
        es = ((n >> (s - 1)) & 1) != 0;
        if (sqw_out != es) bad_sq++;
        if (pflag != ef) bad_fl++;
        if (irq_n != !ef) bad_irq++;
        if (n == p) stat_rd = 1'b1;
      end
      tick = 1'b0;
      if (c < 3) begin
        check(bad_fl == 0, $sformatf("R3 code %0d event period", c), bad_fl, 0);
      end else begin
        check(bad_fl == 0, $sformatf("R2 code %0d event period", c), bad_fl, 0);
      end
      check(bad_sq == 0, $sformatf("R5 code %0d square wave", c), bad_sq, 0);
      check(bad_irq == 0, $sformatf("R9 code %0d read clears irq", c), bad_irq, 0);
    end

    // R4 code 0: nothing
    begin
      int bad;
      bad = 0;
      do_reset(0);
      tick = 1'b1;
      for (int n = 0; n < 300; n++) begin
        step();
        if (pflag || sqw_out || !irq_n) bad++;
      end
      tick = 1'b0;
      check(bad == 0, "R4 code 0 silent", bad, 0);
    end

    // R6 square wave disabled, flag still sets
    begin
      int bad;
      bad = 0;
      sqw_en = 1'b0;
      do_reset(3);
      tick = 1'b1;
      for (int n = 1; n <= 8; n++) begin
        step();
        if (sqw_out) bad++;
        if (n == 4 && !pflag) bad++;
      end
      tick = 1'b0;
      check(bad == 0, "R6 sqw gated, flag kept", bad, 0);
      sqw_en = 1'b1;
    end

    // R7/R8 flag sets without pie_en; irq follows pie_en same cycle
    pie_en = 1'b0;
    do_reset(3);
    tick = 1'b1;
    for (int n = 0; n < 4; n++) step();
    tick = 1'b0;
    step();
    check(pflag == 1, "R7 flag sticky without enable", pflag, 1);
    check(irq_n == 1 && irqf == 0, "R8 irq masked", irq_n, 1);
    pie_en = 1'b1; #1;
    check(irq_n == 0 && irqf == 1, "R8 irq on enable same cycle", irq_n, 0);
    pie_en = 1'b0; #1;
    check(irq_n == 1, "R8 irq off on disable same cycle", irq_n, 1);
    pie_en = 1'b1;

    // R10 read coincides with event
    do_reset(3);
    tick = 1'b1;
    for (int n = 0; n < 3; n++) step();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0; tick = 1'b0;
    check(pflag == 1 && irq_n == 0, "R10 event wins over read", pflag, 1);
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    check(pflag == 0 && irq_n == 1, "R9 later read clears", pflag, 0);

    // R11 rate change mid-count: code 15 for 10 ticks, then code 3
    do_reset(15);
    tick = 1'b1;
    for (int n = 0; n < 10; n++) step();
    rate_sel = 4'd3;
    step();
    check(pflag == 0, "R11 no event at count 10", pflag, 0);
    step();
    check(pflag == 1, "R11 event at count 11 under new code", pflag, 1);
    tick = 1'b0;

    // R12 sparse ticks: event on the fourth tick, not on cycle count
    do_reset(3);
    for (int k = 1; k <= 4; k++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
      step(); step();
      if (k == 3) check(pflag == 0, "R12 no event before fourth tick", pflag, 0);
    end
    check(pflag == 1, "R12 event on fourth tick", pflag, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule